// File: doc/BRIEF.md
# Dictionary-Based Instruction Decompression Engine

This block sits between a small instruction cache and the processor's fetch port. Hot instructions are not stored in full. Each one is replaced by a short codeword, and that codeword is an index into an on-chip reference table holding the complete instruction word. Several such codewords are packed into one 32-bit pseudo instruction. When the engine receives a fetched word, it first decides whether the word is a pseudo instruction or an ordinary instruction. An ordinary instruction goes through untouched. A pseudo instruction is expanded into its instructions, one per cycle, under a valid/ready handshake with the processor.

No further memory access takes place during an expansion. The upstream fetch is simply stalled until the last expanded instruction has been taken. Software fills the reference table through a small write port while the engine is idle. A flush input, for example on a taken branch, drops whatever is left of the current word.

The codeword width is a parameter. An 8-bit index gives a 256-entry table and three codewords per word. A 9-bit index gives a 512-entry table and two codewords per word.

Top module: `instr_expander`

## Requirements
- R1: A fetched word whose bits [31:24] differ from the marker 8'hF5 is delivered to the processor exactly once and unchanged, starting in the cycle after it is taken.
- R2: A word whose bits [31:24] equal 8'hF5 is a pseudo instruction. Its slot k occupies bits [23-k*IDX_W -: IDX_W] for k = 0 up to (24/IDX_W)-1, and the slots are delivered in order of increasing k, so the most significant slot comes first.
- R3: Each delivered instruction of a pseudo instruction equals the reference-table entry addressed by its slot's codeword.
- R4: A slot holding all ones (8'hFF by default) is padding and produces no output. A pseudo instruction made only of padding produces no output at all and leaves the engine idle.
- R5: inReady is high while the engine is idle. It stays low from the cycle after a word is taken until the cycle after the last instruction of that word has been accepted.
- R6: While outValid is high and outReady is low, outValid stays high and outInstr holds its value.
- R7: While flush is high, inReady is low. In the cycle after flush, outValid is low and any undelivered slots are lost.
- R8: A table write (tblWe) takes effect only when the engine is idle. A write attempted while outValid is high leaves the table unchanged.
- R9: After reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the rest of the current word |
| inValid | input | 1 | Fetched word available |
| inWord | input | INSTR_W | Fetched word |
| inReady | output | 1 | Engine will take a word this cycle |
| outValid | output | 1 | Instruction available for the processor |
| outInstr | output | INSTR_W | Instruction for the processor |
| outReady | input | 1 | Processor accepts the instruction |
| tblWe | input | 1 | Reference-table write enable |
| tblAddr | input | IDX_W | Reference-table write index |
| tblData | input | INSTR_W | Reference-table write data |

## Verification
The bench builds the engine with its defaults: 32-bit words, 8-bit codewords, a 256-entry table and three slots per pseudo instruction. With this build every table entry can be loaded with a distinct value. It also lets the bench place padding in the first, middle and last slot positions, and exercise the all-padding word. The 9-bit build, with two slots per word, comes from the same generate logic and the same slot formula, but this bench does not exercise it.

// File: rtl/instr_exp_pkg.sv
package instr_exp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PASS   = 2'd1,
    ST_EXPAND = 2'd2
  } expState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPseudo;  // capture slots of an incoming pseudo instruction
    logic loadPlain;   // capture an incoming plain instruction
    logic advance;     // current slot accepted by the processor
    logic clear;       // drop all pending slots
    logic tblWrite;    // commit a reference-table write
  } dpCtrl_t;

endpackage

// File: rtl/exp_datapath.sv
module exp_datapath
  import instr_exp_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 8,
  parameter int OP_W    = 8,
  parameter logic [OP_W-1:0] MARK = 8'hF5
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic [INSTR_W-1:0] inWord,
  input  logic [IDX_W-1:0]   tblAddr,
  input  logic [INSTR_W-1:0] tblData,
  output logic               inIsPseudo,
  output logic               inHasCode,
  output logic               curIsLast,
  output logic [INSTR_W-1:0] outInstr
);

  localparam int SLOTS = (INSTR_W - OP_W) / IDX_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] PAD = '1;

  logic [INSTR_W-1:0] refTbl [DEPTH];
  logic [INSTR_W-1:0] holdWord;
  logic [IDX_W-1:0]   codes   [SLOTS];
  logic [IDX_W-1:0]   inCodes [SLOTS];
  logic [SLOTS-1:0]   mask;
  logic [SLOTS-1:0]   inMask;
  logic [PTR_W-1:0]   ptr;
  logic               found;

  // Slot extraction, most significant slot first
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign inCodes[g] = inWord[INSTR_W-OP_W-1-g*IDX_W -: IDX_W];
    assign inMask[g]  = (inCodes[g] != PAD);
  end

  assign inIsPseudo = (inWord[INSTR_W-1 -: OP_W] == MARK);
  assign inHasCode  = |inMask;

  // Lowest pending slot index is the next to issue
  always_comb begin
    ptr   = '0;
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (mask[i] && !found) begin
        ptr   = PTR_W'(i);
        found = 1'b1;
      end
    end
  end

  assign curIsLast = ((mask & ~(SLOTS'(1) << ptr)) == '0);
  assign outInstr  = (mask != '0) ? refTbl[codes[ptr]] : holdWord;

  always_ff @(posedge clk) begin
    if (ctrl.tblWrite) refTbl[tblAddr] <= tblData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask     <= '0;
      holdWord <= '0;
      for (int i = 0; i < SLOTS; i++) codes[i] <= '0;
    end else if (ctrl.clear) begin
      mask <= '0;
    end else if (ctrl.loadPseudo) begin
      mask <= inMask;
      for (int i = 0; i < SLOTS; i++) codes[i] <= inCodes[i];
    end else if (ctrl.loadPlain) begin
      mask     <= '0;
      holdWord <= inWord;
    end else if (ctrl.advance) begin
      mask[ptr] <= 1'b0;
    end
  end

  // A padding slot is never selected for issue
  assert_nopad_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mask != '0) |-> (codes[ptr] != PAD));

  // Each accepted slot retires exactly one pending entry
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && !ctrl.clear && mask != '0) |=> ($countones(mask) == $countones($past(mask)) - 1));

endmodule

// File: rtl/exp_ctrl.sv
module exp_ctrl
  import instr_exp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    flush,
  input  logic    tblWe,
  input  logic    inIsPseudo,
  input  logic    inHasCode,
  input  logic    curIsLast,
  output logic    inReady,
  output logic    outValid,
  output dpCtrl_t ctrl
);

  expState_t state, stateNext;
  logic take;

  assign inReady  = (state == ST_IDLE) && !flush;
  assign outValid = (state != ST_IDLE);
  assign take     = inValid && inReady;

  always_comb begin
    ctrl.loadPseudo = take && inIsPseudo && inHasCode;
    ctrl.loadPlain  = take && !inIsPseudo;
    ctrl.advance    = (state == ST_EXPAND) && outReady && !flush;
    ctrl.clear      = flush;
    ctrl.tblWrite   = tblWe && (state == ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    if (flush) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctrl.loadPseudo)     stateNext = ST_EXPAND;
          else if (ctrl.loadPlain) stateNext = ST_PASS;
        end
        ST_PASS:   if (outReady) stateNext = ST_IDLE;
        ST_EXPAND: if (ctrl.advance && curIsLast) stateNext = ST_IDLE;
        default:   stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // Upstream stays stalled while an instruction waits for the processor
  assert_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=> !inReady);

endmodule

// File: rtl/instr_expander.sv
module instr_expander
  import instr_exp_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 8,
  parameter logic [7:0] MARK = 8'hF5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] inWord,
  output logic               inReady,
  output logic               outValid,
  output logic [INSTR_W-1:0] outInstr,
  input  logic               outReady,
  input  logic               tblWe,
  input  logic [IDX_W-1:0]   tblAddr,
  input  logic [INSTR_W-1:0] tblData
);

  localparam int OP_W = 8;

  dpCtrl_t ctrl;
  logic    inIsPseudo, inHasCode, curIsLast;

  exp_ctrl i_ctrl (
    .clk, .rstN, .inValid, .outReady, .flush, .tblWe,
    .inIsPseudo, .inHasCode, .curIsLast,
    .inReady, .outValid, .ctrl
  );

  exp_datapath #(
    .INSTR_W(INSTR_W), .IDX_W(IDX_W), .OP_W(OP_W), .MARK(MARK)
  ) i_dp (
    .clk, .rstN, .ctrl, .inWord, .tblAddr, .tblData,
    .inIsPseudo, .inHasCode, .curIsLast, .outInstr
  );

  assert_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inWord[INSTR_W-1 -: OP_W] != MARK)
      |=> (outValid && outInstr == $past(inWord)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=> (outValid && $stable(outInstr)));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !outValid);

  assert_allpad_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inIsPseudo && !inHasCode) |=> !outValid);

endmodule

// File: tb/test_instr_expander.sv
`timescale 1ns/1ps
module test_instr_expander;

  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    32'hF5010203, 32'h12345678, 32'hF5FF10FF, 32'hF5FFFFFF, 32'hF500FE80,
    32'hF4112233, 32'hF5FFFF07, 32'hF520FFFF, 32'h00000000, 32'hFFFFFFFF
  };

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0;
  logic inValid = 1'b0, inReady, outValid, outReady = 1'b1, tblWe = 1'b0;
  logic [31:0] inWord = '0, outInstr, tblData = '0;
  logic [7:0]  tblAddr = '0;
  logic [31:0] model [256];
  int nChk = 0, nFail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  instr_expander i_instr_expander (
    .clk, .rstN, .flush, .inValid, .inWord, .inReady, .outValid,
    .outInstr, .outReady, .tblWe, .tblAddr, .tblData
  );

  function automatic logic [31:0] entryVal(int i);
    return {8'h5A, 8'(i), 8'(~i), 8'(i ^ 8'h3C)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = a; tblData = d;
    @(posedge clk); #1 tblWe = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk);
    chk(inReady == 1'b1, "R5 ready when idle", {31'b0, inReady}, 32'h1);
    inValid = 1'b1; inWord = w;
    @(posedge clk); #1 inValid = 1'b0;
  endtask

  // Send one word with outReady high and compare the issued stream
  task automatic applyWord(input logic [31:0] w);
    logic [31:0] exp [3];
    int n = 0;
    if (w[31:24] == 8'hF5) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] c = w[23-8*k -: 8];
        if (c != 8'hFF) begin exp[n] = model[c]; n++; end
      end
    end else begin
      exp[0] = w; n = 1;
    end
    outReady = 1'b1;
    sendWord(w);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      chk(outValid && outInstr == exp[j], (w[31:24] == 8'hF5) ? "R2/R3 expanded slot" : "R1 plain passthrough",
          outInstr, exp[j]);
      chk(inReady == 1'b0, "R5 stall during issue", {31'b0, inReady}, 32'h0);
    end
    @(negedge clk);
    chk(outValid == 1'b0, "R4 no extra output after word", {31'b0, outValid}, 32'h0);
    chk(inReady == 1'b1, "R5 ready after last accept", {31'b0, inReady}, 32'h1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nChk++; nFail++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R9 reset outValid", {31'b0, outValid}, 32'h0);
    chk(inReady == 1'b1, "R9 reset inReady", {31'b0, inReady}, 32'h1);

    for (int i = 0; i < 256; i++) begin
      model[i] = entryVal(i);
      writeEntry(8'(i), entryVal(i));
    end

    for (int v = 0; v < NVEC; v++) applyWord(VEC[v]);

    // R6: back-pressure holds the instruction stable
    outReady = 1'b0;
    sendWord(32'hF50405FF);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(outValid && outInstr == model[4], "R6 hold under back-pressure", outInstr, model[4]);
    end
    outReady = 1'b1;
    @(negedge clk);
    chk(outValid && outInstr == model[5], "R6 next slot after release", outInstr, model[5]);
    @(negedge clk);
    chk(!outValid, "R4 trailing pad skipped", {31'b0, outValid}, 32'h0);

    // R7: flush drops the remaining slots
    sendWord(32'hF5070809);
    @(negedge clk);
    chk(outValid && outInstr == model[7], "R7 first slot before flush", outInstr, model[7]);
    flush = 1'b1;
    #0.5 chk(inReady == 1'b0, "R7 not ready during flush", {31'b0, inReady}, 32'h0);
    @(negedge clk);
    flush = 1'b0;
    #0.5 chk(outValid == 1'b0, "R7 idle after flush", {31'b0, outValid}, 32'h0);
    chk(inReady == 1'b1, "R7 ready after flush", {31'b0, inReady}, 32'h1);

    // R8: write while busy is ignored
    outReady = 1'b0;
    sendWord(32'hF50A0B0C);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = 8'h0B; tblData = 32'hDEADBEEF;
    @(negedge clk);
    tblWe = 1'b0; outReady = 1'b1;
    chk(outValid && outInstr == model[10], "R8 busy slot0", outInstr, model[10]);
    @(negedge clk);
    chk(outValid && outInstr == model[11], "R8 busy write ignored", outInstr, model[11]);
    @(negedge clk);
    chk(outValid && outInstr == model[12], "R8 busy slot2", outInstr, model[12]);
    @(negedge clk);
    chk(!outValid, "R8 idle after word", {31'b0, outValid}, 32'h0);

    // R8: write while idle takes effect
    writeEntry(8'h0B, 32'hCAFEF00D);
    model[11] = 32'hCAFEF00D;
    applyWord(32'hF50BFFFF);
    applyWord(32'hF5FF0BFF);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule